// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM organised as 64K words of 4 bits. The host issues one single-word request at a time through a valid/ready handshake. The controller then drives the memory's address lines and its active-low chip-enable, write-enable and output-enable strobes in the order that memory needs. A read result comes back to the host with a one-cycle valid strobe.

Every timing interval of the memory is a parameter counted in whole clock cycles: read access time, write-enable pulse width, data setup before the write-ending edge, minimum write cycle and output float time. Writes are controlled by write enable, with output enable held high for the whole write. Data setup and hold are timed against the rising write-enable edge. After a read there is a float wait, so the memory releases the data bus before the controller drives it again.

Top module: `sram_seq`

## Requirements
- R1: After reset, and at every idle cycle between requests, mem_ce_n, mem_we_n and mem_oe_n are all 1 and req_ready is 1.
- R2: A request is taken on a rising clock edge where req_valid and req_ready are both 1. req_ready then stays 0 and returns to 1 exactly T_AA+T_HZ cycles after that edge for a read (req_write=0), and exactly WL_N+2 cycles after it for a write (req_write=1). Here WL_N is the largest of T_PWE, T_SD and T_WC-2.
- R3: For a read, mem_ce_n and mem_oe_n go low together from the cycle after acceptance, with mem_we_n high and mem_addr equal to req_addr. They stay that way for T_AA cycles. The data bus is sampled at the end of the T_AA-th cycle.
- R4: rd_valid is a single-cycle pulse. It is 1 exactly T_AA cycles after a read is accepted, carrying the sampled word on rd_data, and it never rises for a write.
- R5: A write takes one cycle with mem_ce_n low, mem_we_n high and the data driven. Then mem_we_n is low for exactly WL_N cycles. Then comes one hold cycle with mem_we_n high, mem_ce_n low and the data still driven. mem_oe_n stays 1 for the whole write, and mem_we_n and mem_oe_n are never low together.
- R6: While mem_we_n is low, mem_addr and the data on mem_dq do not change.
- R7: After a read, mem_ce_n and mem_oe_n are high for at least T_HZ+1 cycles before mem_ce_n falls again.
- R8: After a write, mem_ce_n is high for at least one cycle, with the controller's data drivers off, before the next access starts.
- R9: A word written to any address is returned unchanged by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle strobe marking rd_data valid |
| rd_data | output | DATA_W | Word captured by the last read |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | inout | DATA_W | Bidirectional data bus, driven only during writes |

## Verification
Every result is timed in cycles from the accepting edge.
- **Reads:** rd_valid and the returned word are due exactly T_AA cycles after that edge. req_ready comes back after T_AA+T_HZ cycles.
- **Writes:** req_ready comes back after WL_N+2 cycles.
- **How the bench samples:** it counts falling edges from the accepting edge and checks each output at the count where it is due, and also checks that it is absent at every other count.
- **Memory model:** the attached model drives wrong data until chip enable has been low for T_AA cycles, so a capture that comes too early returns a mismatch.
- **Strobe monitor:** it measures the write-enable width, the stability of address and data, and the deselect gap before each access in whole cycles.

// File: rtl/sram_seq.sv
module sram_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4,
  parameter int T_AA   = 3,
  parameter int T_PWE  = 2,
  parameter int T_SD   = 1,
  parameter int T_WC   = 3,
  parameter int T_HZ   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int WL_A = (T_PWE > T_SD) ? T_PWE : T_SD;
  localparam int WL_N = (WL_A > T_WC - 2) ? WL_A : T_WC - 2;
  localparam int MX_A = (T_AA > T_HZ) ? T_AA : T_HZ;
  localparam int MX_C = (MX_A > WL_N) ? MX_A : WL_N;
  localparam int CW   = $clog2(MX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_FLT, S_WA, S_WL, S_WH} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] aq;
  logic [DATA_W-1:0] wq;
  logic              drv;

  assign req_ready = (st == S_IDLE);
  assign mem_ce_n  = !(st inside {S_RD, S_WA, S_WL, S_WH});
  assign mem_we_n  = (st != S_WL);
  assign mem_oe_n  = (st != S_RD);
  assign drv       = (st inside {S_WA, S_WL, S_WH});
  assign mem_addr  = aq;
  assign mem_dq    = drv ? wq : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      aq       <= '0;
      wq       <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          aq  <= req_addr;
          wq  <= req_wdata;
          cnt <= '0;
          st  <= req_write ? S_WA : S_RD;
        end
        S_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_AA - 1)) begin
            rd_data  <= mem_dq;
            rd_valid <= 1'b1;
            cnt      <= '0;
            st       <= S_FLT;
          end
        end
        S_FLT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_HZ - 1)) st <= S_IDLE;
        end
        S_WA: begin
          cnt <= '0;
          st  <= S_WL;
        end
        S_WL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(WL_N - 1)) st <= S_WH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n)); // R1
  AST_RD_JOINT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $fell(mem_ce_n)); // R3
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R5
  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq)); // R6
endmodule

// File: tb/sim_sram_seq.sv
module sim_sram_seq;
  localparam int AW   = 6;
  localparam int TAA  = 3;
  localparam int TPWE = 2;
  localparam int TSD  = 1;
  localparam int TWC  = 5;
  localparam int THZ  = 2;
  localparam int WLA  = (TPWE > TSD) ? TPWE : TSD;
  localparam int WLN  = (WLA > TWC - 2) ? WLA : TWC - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_wdata = '0;
  logic          req_ready, rd_valid, ce_n, we_n, oe_n;
  logic [3:0]    rd_data;
  logic [AW-1:0] addr;
  wire  [3:0]    dq;

  sram_seq #(.ADDR_W(AW), .DATA_W(4), .T_AA(TAA), .T_PWE(TPWE), .T_SD(TSD),
             .T_WC(TWC), .T_HZ(THZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(addr),
    .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_dq(dq));

  logic [3:0] mem [0:63];
  int acnt = 0;
  wire mact = !ce_n && we_n && !oe_n;
  assign dq = mact ? ((acnt >= TAA - 1) ? mem[addr] : ~mem[addr]) : 4'bz;
  always @(posedge clk) acnt <= ce_n ? 0 : acnt + 1;
  always @(posedge we_n) if (ce_n === 1'b0) mem[addr] <= dq;

  int tests = 0, fails = 0;
  int we_lo = 0, ce_hi = 100;
  int v_pw = 0, v_stab = 0, v_gap = 0, v_weoe = 0;
  logic last_rd = 1'b0, pwe = 1'b1, pce = 1'b1;
  logic [3:0] pdq = '0;
  logic [AW-1:0] pad = '0;
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (!we_n && !oe_n) v_weoe++;
    if (!we_n) begin
      if (!pwe && (dq !== pdq || addr !== pad)) v_stab++;
      we_lo++;
    end else begin
      if (!pwe && we_lo != WLN) v_pw++;
      we_lo = 0;
    end
    if (ce_n) ce_hi++;
    else begin
      if (pce && ce_hi < (last_rd ? THZ + 1 : 1)) v_gap++;
      if (pce) last_rd = !oe_n;
      ce_hi = 0;
    end
    pwe = we_n; pce = ce_n; pdq = dq; pad = addr;
  end

  task automatic ck(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [3:0] d, input logic [3:0] exp);
    int tot;
    bit lat_ok;
    bit seen;
    int vn;
    logic [3:0] got;
    tot = w ? WLN + 2 : TAA + THZ;
    lat_ok = 1; seen = 0; vn = -1; got = '0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (req_ready || rd_valid) lat_ok = 0;
    for (int n = 1; n <= tot; n++) begin
      @(negedge clk);
      if (rd_valid) begin
        vn = n;
        if (w || n != TAA || seen) lat_ok = 0;
        else begin seen = 1; got = rd_data; end
      end
      if (n < tot && req_ready) lat_ok = 0;
      if (n == tot && !req_ready) lat_ok = 0;
    end
    ck(lat_ok, "R2", "handshake/strobe latency", vn, w ? -1 : TAA);
    ck(ce_n && we_n && oe_n, "R1", "idle strobes after request", {ce_n, we_n, oe_n}, 7);
    if (!w) begin
      ck(seen, "R4", "read valid pulse seen", seen, 1);
      ck(got == exp, "R9", "read data", got, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int a, input int k);
    return 4'((a * k + 3) & 15);
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ck(ce_n && we_n && oe_n && req_ready && !rd_valid, "R1", "reset state",
       {ce_n, we_n, oe_n, req_ready, rd_valid}, 5'b11110);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 64; a++) do_req(1, AW'(a), pat(a, 7), 4'h0);
    for (int a = 63; a >= 0; a--) do_req(0, AW'(a), 4'h0, pat(a, 7));
    for (int a = 0; a < 64; a++) begin
      do_req(1, AW'(a), pat(a, 5) ^ 4'hA, 4'h0);
      do_req(0, AW'(a), 4'h0, pat(a, 5) ^ 4'hA);
      do_req(0, AW'(63 - a), 4'h0, (63 - a) > a ? pat(63 - a, 7) : (pat(63 - a, 5) ^ 4'hA));
    end
    for (int a = 0; a < 4; a++) begin
      do_req(1, AW'(a), 4'hF, 4'h0);
      do_req(1, AW'(a), 4'h0, 4'h0);
      do_req(0, AW'(a), 4'h0, 4'h0);
    end
    ck(v_weoe == 0, "R5", "write and output enable low together", v_weoe, 0);
    ck(v_pw == 0, "R5", "write-enable low width wrong", v_pw, 0);
    ck(v_stab == 0, "R6", "address/data moved under write enable", v_stab, 0);
    ck(v_gap == 0, "R7", "deselect gap before access too short (R8 after write)", v_gap, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R2: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule